// File: doc/BRIEF.md
# Optimistic Epoch Coherence Checker with Hashed Address Signatures

This block lets a near-data accelerator run an offloaded kernel without coherence traffic while the host CPU keeps running. For the length of an optimistic epoch, accelerator accesses raise no coherence requests. Instead, every line address is hashed into one of three Bloom-filter signatures. One signature holds lines the accelerator read, one holds lines the accelerator wrote, and one holds lines the CPU wrote.

When the epoch is closed, the block intersects the CPU-write signature with each accelerator signature and gives a verdict to the CPU-side resolver. On a clean verdict, the resolver acknowledges and the block pulses a clear of the uncommitted flags in the accelerator cache. Optimistic execution then continues, or the block goes idle if the kernel has finished. On a conflict, the acknowledge instead produces a rollback pulse. That pulse invalidates the uncommitted accelerator updates and makes the accelerator re-execute the uncommitted part of the kernel. Because of hash aliasing, a false positive can cause an unneeded rollback, but a real conflict is never missed.

Top module: `sig_coh_checker`

## Requirements
- R1: After a synchronous reset, `state_o` is 0 (idle) and `coh_req_o`, `verdict_vld_o`, `rd_conflict_o`, `wr_conflict_o`, `clr_uncommitted_o` and `rollback_o` are all low.
- R2: In the idle state, a valid accelerator read or write makes `coh_req_o` high in the next cycle for one cycle. An `epoch_start_i` seen in idle moves `state_o` to 1 (optimistic) in the next cycle.
- R3: While `state_o` is not 0, accelerator accesses never raise `coh_req_o`.
- R4: Each signature has 2^HASH_W bits. A line address is zero-padded to a multiple of HASH_W bits and cut into HASH_W-bit slices, slice k starting at bit k*HASH_W. Index A is the XOR of all slices. Index B is the XOR of all slices, with slice k first rotated left by k+1 bit positions. An insert sets bits A and B.
- R5: An `epoch_end_i` seen in state 1 gives state 2 (check) in the next cycle. One cycle later the state is 3 (commit) or 4 (abort), with `verdict_vld_o` high.
- R6: `rd_conflict_o` is set in the verdict when the accelerator-read and CPU-write signatures share a set bit.
- R7: `wr_conflict_o` is set in the verdict when the accelerator-write and CPU-write signatures share a set bit.
- R8: The verdict is abort (4) exactly when R6 or R7 holds, and commit (3) otherwise.
- R9: `resolve_ack_i` in state 3 gives a one-cycle `clr_uncommitted_o` pulse in the next cycle. The state then becomes 0 if `kernel_done_i` was seen since the epoch began, and 1 otherwise.
- R10: `resolve_ack_i` in state 4 gives a one-cycle `rollback_o` pulse and state 1, even when the kernel reported done. The done record is discarded.
- R11: All three signatures are emptied in the acknowledge cycle. An insertion presented in that same cycle is kept for the next epoch.
- R12: Without `resolve_ack_i`, state 3 or 4 and its conflict flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| epoch_start_i | input | 1 | Begin optimistic execution of a kernel |
| epoch_end_i | input | 1 | Close the current optimistic epoch |
| kernel_done_i | input | 1 | Kernel has finished its work |
| acc_rd_vld_i | input | 1 | Accelerator read valid |
| acc_rd_line_i | input | LINE_W | Accelerator read line address |
| acc_wr_vld_i | input | 1 | Accelerator write valid |
| acc_wr_line_i | input | LINE_W | Accelerator write line address |
| cpu_wr_vld_i | input | 1 | CPU write valid |
| cpu_wr_line_i | input | LINE_W | CPU write line address |
| resolve_ack_i | input | 1 | CPU-side resolver has finished its coherence actions |
| coh_req_o | output | 1 | Coherence request for a non-optimistic accelerator access |
| state_o | output | 3 | Epoch state: 0 idle, 1 optimistic, 2 check, 3 commit, 4 abort |
| verdict_vld_o | output | 1 | A verdict is waiting for acknowledge |
| rd_conflict_o | output | 1 | Read-set conflict in the last verdict |
| wr_conflict_o | output | 1 | Write-set conflict in the last verdict |
| clr_uncommitted_o | output | 1 | Pulse: clear uncommitted flags (commit) |
| rollback_o | output | 1 | Pulse: invalidate uncommitted updates and re-execute (abort) |

## Verification
Signature contents can only be seen through verdicts. The bench therefore builds epochs whose expected overlap it derives from the hash definition. A signature that lost a bit, kept a stale bit or was not cleared shows up as a wrong commit or abort in the second cycle after the epoch closes. A leak across the acknowledge boundary shows up in the verdict of the following epoch. A state machine fault shows up in `state_o` or in a misplaced pulse one cycle after the acknowledge.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_OPT    = 3'd1,
    ST_CHECK  = 3'd2,
    ST_COMMIT = 3'd3,
    ST_ABORT  = 3'd4
  } epoch_st_e;

  localparam int NUM_SIG    = 3;
  localparam int IDX_ACC_RD = 0;
  localparam int IDX_ACC_WR = 1;
  localparam int IDX_CPU_WR = 2;
endpackage

// File: rtl/coh_line_hash.sv
module coh_line_hash #(
  parameter int LINE_W = 26,
  parameter int HASH_W = 10
) (
  input  logic [LINE_W-1:0] line_i,
  output logic [HASH_W-1:0] idx_a_o,
  output logic [HASH_W-1:0] idx_b_o
);
  localparam int NSL   = (LINE_W + HASH_W - 1) / HASH_W;
  localparam int PAD_W = NSL * HASH_W;

  logic [PAD_W-1:0] pad;
  assign pad = PAD_W'(line_i);

  // Index A: plain XOR fold of the slices. Index B: slice k is rotated
  // left by k+1 positions before folding, which decorrelates it from A.
  always_comb begin
    idx_a_o = '0;
    idx_b_o = '0;
    for (int k = 0; k < NSL; k++) begin
      for (int b = 0; b < HASH_W; b++) begin
        idx_a_o[b] = idx_a_o[b] ^ pad[k*HASH_W + b];
        idx_b_o[(b + k + 1) % HASH_W] = idx_b_o[(b + k + 1) % HASH_W] ^ pad[k*HASH_W + b];
      end
    end
  end
endmodule

// File: rtl/coh_sig_filter.sv
module coh_sig_filter #(
  parameter int HASH_W = 10,
  localparam int SIG_BITS = 1 << HASH_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  input  logic                ins_i,
  input  logic [HASH_W-1:0]   idx_a_i,
  input  logic [HASH_W-1:0]   idx_b_i,
  output logic [SIG_BITS-1:0] sig_o
);
  logic [SIG_BITS-1:0] ins_bits;

  always_comb begin
    ins_bits = '0;
    if (ins_i) begin
      ins_bits[idx_a_i] = 1'b1;
      ins_bits[idx_b_i] = 1'b1;
    end
  end

  // A clear starts a fresh set that already holds the same-cycle insertion.
  always_ff @(posedge clk) begin
    if (rst)        sig_o <= '0;
    else if (clr_i) sig_o <= ins_bits;
    else            sig_o <= sig_o | ins_bits;
  end
endmodule

// File: rtl/coh_epoch_fsm.sv
module coh_epoch_fsm
  import coh_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      epoch_start_i,
  input  logic      epoch_end_i,
  input  logic      kernel_done_i,
  input  logic      resolve_ack_i,
  input  logic      rd_hit_i,
  input  logic      wr_hit_i,
  output epoch_st_e state_o,
  output logic      sig_clr_o,
  output logic      ins_en_o,
  output logic      rd_flag_o,
  output logic      wr_flag_o,
  output logic      clr_pulse_o,
  output logic      rollback_o
);
  logic done_seen;

  assign sig_clr_o = resolve_ack_i && (state_o == ST_COMMIT || state_o == ST_ABORT);
  assign ins_en_o  = (state_o != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o     <= ST_IDLE;
      done_seen   <= 1'b0;
      rd_flag_o   <= 1'b0;
      wr_flag_o   <= 1'b0;
      clr_pulse_o <= 1'b0;
      rollback_o  <= 1'b0;
    end else begin
      clr_pulse_o <= 1'b0;
      rollback_o  <= 1'b0;
      case (state_o)
        ST_IDLE: begin
          done_seen <= 1'b0;
          if (epoch_start_i) state_o <= ST_OPT;
        end
        ST_OPT: begin
          if (kernel_done_i) done_seen <= 1'b1;
          if (epoch_end_i)   state_o   <= ST_CHECK;
        end
        ST_CHECK: begin
          if (kernel_done_i) done_seen <= 1'b1;
          rd_flag_o <= rd_hit_i;
          wr_flag_o <= wr_hit_i;
          state_o   <= (rd_hit_i || wr_hit_i) ? ST_ABORT : ST_COMMIT;
        end
        ST_COMMIT: begin
          if (resolve_ack_i) begin
            clr_pulse_o <= 1'b1;
            done_seen   <= 1'b0;
            state_o     <= (done_seen || kernel_done_i) ? ST_IDLE : ST_OPT;
          end else if (kernel_done_i) begin
            done_seen <= 1'b1;
          end
        end
        ST_ABORT: begin
          if (resolve_ack_i) begin
            rollback_o <= 1'b1;
            done_seen  <= 1'b0;
            state_o    <= ST_OPT;
          end
        end
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sig_coh_checker.sv
module sig_coh_checker
  import coh_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int HASH_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              epoch_start_i,
  input  logic              epoch_end_i,
  input  logic              kernel_done_i,
  input  logic              acc_rd_vld_i,
  input  logic [LINE_W-1:0] acc_rd_line_i,
  input  logic              acc_wr_vld_i,
  input  logic [LINE_W-1:0] acc_wr_line_i,
  input  logic              cpu_wr_vld_i,
  input  logic [LINE_W-1:0] cpu_wr_line_i,
  input  logic              resolve_ack_i,
  output logic              coh_req_o,
  output logic [2:0]        state_o,
  output logic              verdict_vld_o,
  output logic              rd_conflict_o,
  output logic              wr_conflict_o,
  output logic              clr_uncommitted_o,
  output logic              rollback_o
);
  localparam int SIG_BITS = 1 << HASH_W;

  epoch_st_e         st;
  logic              sig_clr, ins_en, rd_hit, wr_hit;
  logic [NUM_SIG-1:0] src_vld;
  logic [LINE_W-1:0]  src_line [NUM_SIG];
  logic [SIG_BITS-1:0] sig [NUM_SIG];

  assign src_vld[IDX_ACC_RD]  = acc_rd_vld_i;
  assign src_vld[IDX_ACC_WR]  = acc_wr_vld_i;
  assign src_vld[IDX_CPU_WR]  = cpu_wr_vld_i;
  assign src_line[IDX_ACC_RD] = acc_rd_line_i;
  assign src_line[IDX_ACC_WR] = acc_wr_line_i;
  assign src_line[IDX_CPU_WR] = cpu_wr_line_i;

  for (genvar g = 0; g < NUM_SIG; g++) begin : g_sig
    logic [HASH_W-1:0] ia, ib;
    coh_line_hash #(.LINE_W(LINE_W), .HASH_W(HASH_W)) u_hash (
      .line_i (src_line[g]),
      .idx_a_o(ia),
      .idx_b_o(ib)
    );
    coh_sig_filter #(.HASH_W(HASH_W)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (sig_clr),
      .ins_i  (src_vld[g] && ins_en),
      .idx_a_i(ia),
      .idx_b_i(ib),
      .sig_o  (sig[g])
    );
  end

  assign rd_hit = |(sig[IDX_ACC_RD] & sig[IDX_CPU_WR]);
  assign wr_hit = |(sig[IDX_ACC_WR] & sig[IDX_CPU_WR]);

  coh_epoch_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .epoch_start_i(epoch_start_i),
    .epoch_end_i  (epoch_end_i),
    .kernel_done_i(kernel_done_i),
    .resolve_ack_i(resolve_ack_i),
    .rd_hit_i     (rd_hit),
    .wr_hit_i     (wr_hit),
    .state_o      (st),
    .sig_clr_o    (sig_clr),
    .ins_en_o     (ins_en),
    .rd_flag_o    (rd_conflict_o),
    .wr_flag_o    (wr_conflict_o),
    .clr_pulse_o  (clr_uncommitted_o),
    .rollback_o   (rollback_o)
  );

  assign state_o       = st;
  assign verdict_vld_o = (st == ST_COMMIT) || (st == ST_ABORT);

  always_ff @(posedge clk) begin
    if (rst) coh_req_o <= 1'b0;
    else     coh_req_o <= (st == ST_IDLE) && (acc_rd_vld_i || acc_wr_vld_i);
  end
endmodule

// File: rtl/coh_checker_sva.sv
module coh_checker_sva (
  input logic       clk,
  input logic       rst,
  input logic       resolve_ack_i,
  input logic       coh_req_o,
  input logic [2:0] state_o,
  input logic       rd_conflict_o,
  input logic       wr_conflict_o,
  input logic       clr_uncommitted_o,
  input logic       rollback_o
);
  assert_no_req_in_epoch_R3: assert property (@(posedge clk) disable iff (rst)
    coh_req_o |-> ($past(state_o) == 3'd0));

  assert_check_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2) |=> (state_o == 3'd3 || state_o == 3'd4));

  assert_commit_clean_R8: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3) |-> !(rd_conflict_o || wr_conflict_o));

  assert_abort_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4) |-> (rd_conflict_o || wr_conflict_o));

  assert_clear_after_ack_R9: assert property (@(posedge clk) disable iff (rst)
    clr_uncommitted_o |-> ($past(state_o) == 3'd3 && $past(resolve_ack_i)));

  assert_rollback_resumes_R10: assert property (@(posedge clk) disable iff (rst)
    rollback_o |-> (state_o == 3'd1 && !clr_uncommitted_o));

  assert_verdict_holds_R12: assert property (@(posedge clk) disable iff (rst)
    ((state_o == 3'd3 || state_o == 3'd4) && !resolve_ack_i) |=>
      ($stable(state_o) && $stable(rd_conflict_o) && $stable(wr_conflict_o)));
endmodule

bind sig_coh_checker coh_checker_sva u_sva (
  .clk              (clk),
  .rst              (rst),
  .resolve_ack_i    (resolve_ack_i),
  .coh_req_o        (coh_req_o),
  .state_o          (state_o),
  .rd_conflict_o    (rd_conflict_o),
  .wr_conflict_o    (wr_conflict_o),
  .clr_uncommitted_o(clr_uncommitted_o),
  .rollback_o       (rollback_o)
);

// File: tb/sig_coh_checker_tb.sv
module sig_coh_checker_tb;
  localparam int LW = 26;
  localparam int HW = 10;
  localparam int NV = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic epoch_start_i = 0, epoch_end_i = 0, kernel_done_i = 0, resolve_ack_i = 0;
  logic acc_rd_vld_i = 0, acc_wr_vld_i = 0, cpu_wr_vld_i = 0;
  logic [LW-1:0] acc_rd_line_i = '0, acc_wr_line_i = '0, cpu_wr_line_i = '0;
  logic coh_req_o, verdict_vld_o, rd_conflict_o, wr_conflict_o, clr_uncommitted_o, rollback_o;
  logic [2:0] state_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  sig_coh_checker #(.LINE_W(LW), .HASH_W(HW)) u_dut (.*);

  localparam logic [LW-1:0] V_RD  [NV] = '{26'h0001000, 26'h0003000, 26'h0006000, 26'h3FFFFFF, 26'h1234567, 26'h0000010};
  localparam logic [LW-1:0] V_WR  [NV] = '{26'h0002040, 26'h0004000, 26'h0007080, 26'h0000001, 26'h0ABCDEF, 26'h0000020};
  localparam logic [LW-1:0] V_CPU [NV] = '{26'h0001000, 26'h0005000, 26'h0007080, 26'h3FFFFFF, 26'h0ABCDEF, 26'h0000100};
  localparam bit            V_KD  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  // Index per R4: sel=0 plain fold, sel=1 fold with slice k rotated left by k+1.
  function automatic logic [HW-1:0] hidx(input logic [LW-1:0] l, input bit sel);
    logic [29:0] p;
    logic [HW-1:0] r;
    p = 30'(l);
    r = '0;
    for (int k = 0; k < 3; k++)
      for (int b = 0; b < HW; b++)
        if (sel) r[(b + k + 1) % HW] ^= p[k*HW + b];
        else     r[b] ^= p[k*HW + b];
    return r;
  endfunction

  function automatic bit overlap(input logic [LW-1:0] a, input logic [LW-1:0] c);
    return hidx(a,0) == hidx(c,0) || hidx(a,0) == hidx(c,1) ||
           hidx(a,1) == hidx(c,0) || hidx(a,1) == hidx(c,1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // One full epoch from idle or optimistic; ack-cycle CPU write optional (R11).
  task automatic epoch(input bit rv, input logic [LW-1:0] rl, input bit wv, input logic [LW-1:0] wl,
                       input bit cv, input logic [LW-1:0] cl, input bit kd,
                       input bit ackc, input logic [LW-1:0] ackl,
                       input bit exp_rd, input bit exp_wr, input logic [2:0] exp_next);
    if (state_o == 3'd0) begin
      epoch_start_i = 1; step(); epoch_start_i = 0;
      chk(state_o == 3'd1, "R2 start->optimistic", state_o, 1);
    end
    acc_rd_vld_i = rv; acc_rd_line_i = rl;
    acc_wr_vld_i = wv; acc_wr_line_i = wl;
    cpu_wr_vld_i = cv; cpu_wr_line_i = cl;
    step();
    chk(coh_req_o == 0, "R3 no request in epoch", coh_req_o, 0);
    acc_rd_vld_i = 0; acc_wr_vld_i = 0; cpu_wr_vld_i = 0;
    epoch_end_i = 1; kernel_done_i = kd; step(); epoch_end_i = 0; kernel_done_i = 0;
    chk(state_o == 3'd2, "R5 check state", state_o, 2);
    step();
    chk(state_o == ((exp_rd || exp_wr) ? 3'd4 : 3'd3), "R8 verdict", state_o, (exp_rd || exp_wr) ? 4 : 3);
    chk(verdict_vld_o == 1, "R5 verdict valid", verdict_vld_o, 1);
    chk(rd_conflict_o == exp_rd, "R6 read conflict", rd_conflict_o, exp_rd);
    chk(wr_conflict_o == exp_wr, "R7 write conflict", wr_conflict_o, exp_wr);
    step();
    chk(state_o == ((exp_rd || exp_wr) ? 3'd4 : 3'd3), "R12 verdict holds", state_o, (exp_rd || exp_wr) ? 4 : 3);
    resolve_ack_i = 1; cpu_wr_vld_i = ackc; cpu_wr_line_i = ackl;
    step();
    resolve_ack_i = 0; cpu_wr_vld_i = 0;
    chk(state_o == exp_next, "R9/R10 next state", state_o, exp_next);
    chk(clr_uncommitted_o == !(exp_rd || exp_wr), "R9 clear pulse", clr_uncommitted_o, !(exp_rd || exp_wr));
    chk(rollback_o == (exp_rd || exp_wr), "R10 rollback pulse", rollback_o, exp_rd || exp_wr);
    step();
    chk(!clr_uncommitted_o && !rollback_o, "R9 R10 single-cycle pulse", clr_uncommitted_o | rollback_o, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk(state_o == 3'd0, "R1 reset state", state_o, 0);
    chk({coh_req_o, verdict_vld_o, rd_conflict_o, wr_conflict_o, clr_uncommitted_o, rollback_o} == 6'b0,
        "R1 outputs low", 0, 0);
    // R2 idle access raises a request one cycle later
    acc_rd_vld_i = 1; acc_rd_line_i = 26'h123; step(); acc_rd_vld_i = 0;
    chk(coh_req_o == 1, "R2 idle request", coh_req_o, 1);
    step();
    chk(coh_req_o == 0, "R2 request one cycle", coh_req_o, 0);

    // Vector table, expectations derived from the R4 hash
    for (int i = 0; i < NV; i++) begin
      bit er, ew;
      er = overlap(V_RD[i], V_CPU[i]);
      ew = overlap(V_WR[i], V_CPU[i]);
      epoch(1, V_RD[i], 1, V_WR[i], 1, V_CPU[i], V_KD[i], 0, '0, er, ew,
            (er || ew) ? 3'd1 : (V_KD[i] ? 3'd0 : 3'd1));
    end
    // Ensure a known idle start for the directed part
    if (state_o != 3'd0) epoch(0, '0, 0, '0, 0, '0, 1, 0, '0, 0, 0, 3'd0);

    // R11: CPU write in the ack cycle survives into the next epoch
    epoch(1, 26'h50, 1, 26'h60, 0, '0, 0, 1, 26'h300, 0, 0, 3'd1);
    // R10: abort with kernel done still resumes optimistic execution
    epoch(1, 26'h300, 0, '0, 0, '0, 1, 0, '0, 1, 0, 3'd1);
    // R11: abort emptied the signatures, so the same read now commits; R9 done -> idle
    epoch(1, 26'h300, 0, '0, 0, '0, 1, 0, '0, 0, 0, 3'd0);
    // R6: no false negative on identical line in read and CPU write sets
    epoch(1, 26'h2AAAAAA, 0, '0, 1, 26'h2AAAAAA, 1, 0, '0, 1, 0, 3'd1);
    epoch(0, '0, 0, '0, 0, '0, 1, 0, '0, 0, 0, 3'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule